// File: doc/BRIEF.md
# Carrier Burst Generator

The block turns a stream of clock-enable ticks into a square-wave carrier whose frequency and duty cycle can be programmed. It sends that carrier out as a burst that holds an exact number of carrier periods. A 4-bit divider produces the phase step. A 2-bit phase counter steps through four phases in each carrier period. Together the two form a 6-bit prescaler: the divider sets the length of a phase, and the phase count sets how much of each period is high. An 8-bit counter counts the remaining carrier periods. When it runs out, the block forces the output low and gives a one-cycle completion pulse.

A serial data bit gates each carrier period. When that bit is 0 the carrier stays quiet for the whole period, but the period still counts toward the burst length. The block samples the gate only where a period begins, so it never produces a clipped carrier pulse. Software writes three settings through a small write port: the phase length, the duty and the burst length. Writing the burst length starts a burst. The serial data bit is a plain level and has no handshake. It is read only at period starts, so it applies no back-pressure, and the source only has to hold it steady at those edges. All other pins are plain control and status pins.

Top module: `carrier_burst_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `car_out`, `active` and `burst_done` are all 0.
- R2: A write to address 2 starts a burst. The burst length field is `cfg_wdata[7:0]`. From the next cycle, `active` is 1 and the carrier is at the start of a period, in phase 0.
- R3: A write to address 0 sets z = `cfg_wdata[3:0]`. Each phase lasts z+1 enabled ticks, and each carrier period lasts 4·(z+1) enabled ticks.
- R4: A write to address 1 sets the duty d = `cfg_wdata[1:0]`. Within a period, `car_out` is high during phases 0 through d−1 and low in the other phases. With d = 0 the output stays low.
- R5: With a burst length of y, the burst lasts exactly y+1 carrier periods. After the last period, `active` and `car_out` are both 0.
- R6: `burst_done` is high for exactly one cycle. That cycle comes right after the edge that closes the last period.
- R7: `ser_data` is sampled when the burst starts and at each period boundary, and the sampled value holds for the whole period. A 0 keeps `car_out` low for that period, but the period still counts toward the burst length.
- R8: When `tick_en` is low, the phase divider and the period count hold their values. Only enabled ticks advance the burst.
- R9: While `active` is 1, writes to addresses 0 and 1 are dropped. The phase length and duty of the running burst do not change.
- R10: A write to address 2 while a burst is running restarts the burst from phase 0 with the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 phase length, 1 duty, 2 burst length and start |
| cfg_wdata | input | 8 | Register write data |
| tick_en | input | 1 | Prescaler clock enable |
| ser_data | input | 1 | Serial data bit that gates the carrier for each period |
| car_out | output | 1 | Gated carrier output |
| active | output | 1 | A burst is running |
| burst_done | output | 1 | One-cycle pulse when a burst ends |

## Verification
The edge that captures a start write puts the block in phase 0 with `active` high. From then on, the output state is a pure function of the number of enabled ticks counted since that edge. The bench therefore keeps its own tick count and samples every output on the falling edge of each cycle. At each sample it compares `car_out`, `active` and `burst_done` with values computed from that count, from z, d and y, and from the gate pattern it drove. It sets `ser_data` for period j before the edge at which the tick count reaches j·4·(z+1). It expects `burst_done` only in the single sample taken just after the tick count reaches (y+1)·4·(z+1).

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  localparam int DIV_W  = 4;
  localparam int DUTY_W = 2;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_PHASE_LEN = 2'd0,
    REG_DUTY      = 2'd1,
    REG_BURST     = 2'd2,
    REG_SPARE     = 2'd3
  } cbg_reg_e;
endpackage

// File: rtl/cbg_prescaler.sv
module cbg_prescaler #(
  parameter int DIV_W = 4,
  parameter int PH_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [DIV_W-1:0] div_lim,
  output logic [PH_W-1:0]  phase,
  output logic             period_end
);
  localparam logic [PH_W-1:0] LAST_PHASE = {PH_W{1'b1}};

  logic [DIV_W-1:0] div_q;
  logic [PH_W-1:0]  phase_q;
  logic             div_wrap;

  assign div_wrap   = adv && (div_q == div_lim);
  assign period_end = div_wrap && (phase_q == LAST_PHASE);
  assign phase      = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= '0;
    end else if (clear) begin
      div_q   <= '0;
      phase_q <= '0;
    end else if (adv) begin
      if (div_wrap) begin
        div_q   <= '0;
        phase_q <= phase_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (div_q <= div_lim)); // R3

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clear) |=> ($stable(div_q) && $stable(phase_q))); // R8
endmodule

// File: rtl/cbg_pulse_gate.sv
module cbg_pulse_gate #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt_init,
  input  logic             period_end,
  input  logic             ser_data,
  output logic             run,
  output logic             gate,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             gate_q;
  logic             done_q;

  assign run  = run_q;
  assign gate = gate_q;
  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      gate_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        run_q  <= 1'b1;
        cnt_q  <= cnt_init;
        gate_q <= ser_data;
      end else if (run_q && period_end) begin
        if (cnt_q == '0) begin
          run_q  <= 1'b0;
          gate_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q  <= cnt_q - 1'b1;
          gate_q <= ser_data;
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!run_q && $past(run_q))); // R5

  AST_GATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_q) |-> $past(start || (run_q && period_end))); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && period_end && !start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
endmodule

// File: rtl/carrier_burst_gen.sv
module carrier_burst_gen
  import cbg_pkg::*;
#(
  parameter int P_DIV_W  = DIV_W,
  parameter int P_DUTY_W = DUTY_W,
  parameter int P_CNT_W  = CNT_W,
  parameter int P_DATA_W = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [P_DATA_W-1:0] cfg_wdata,
  input  logic                tick_en,
  input  logic                ser_data,
  output logic                car_out,
  output logic                active,
  output logic                burst_done
);
  logic [P_DIV_W-1:0]  div_lim_q;
  logic [P_DUTY_W-1:0] duty_q;
  logic [P_DUTY_W-1:0] phase;
  logic                period_end;
  logic                run;
  logic                gate;
  logic                start;
  logic                cfg_open;

  assign start    = cfg_we && (cfg_addr == REG_BURST);
  assign cfg_open = cfg_we && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lim_q <= '0;
      duty_q    <= '0;
    end else if (cfg_open) begin
      if (cfg_addr == REG_PHASE_LEN) div_lim_q <= cfg_wdata[P_DIV_W-1:0];
      if (cfg_addr == REG_DUTY)      duty_q    <= cfg_wdata[P_DUTY_W-1:0];
    end
  end

  cbg_prescaler #(
    .DIV_W (P_DIV_W),
    .PH_W  (P_DUTY_W)
  ) u_prescaler (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .adv        (run && tick_en),
    .div_lim    (div_lim_q),
    .phase      (phase),
    .period_end (period_end)
  );

  cbg_pulse_gate #(
    .CNT_W (P_CNT_W)
  ) u_pulse_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cnt_init   (cfg_wdata[P_CNT_W-1:0]),
    .period_end (period_end),
    .ser_data   (ser_data),
    .run        (run),
    .gate       (gate),
    .done       (burst_done)
  );

  assign active  = run;
  assign car_out = run && gate && (phase < duty_q);

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !car_out); // R5

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> ($stable(div_lim_q) && $stable(duty_q))); // R9

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active); // R2
endmodule

// File: tb/test_carrier_burst_gen.sv
module test_carrier_burst_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       tick_en = 1'b1;
  logic       ser_data = 1'b1;
  logic       car_out;
  logic       active;
  logic       burst_done;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  carrier_burst_gen i_carrier_burst_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .tick_en    (tick_en),
    .ser_data   (ser_data),
    .car_out    (car_out),
    .active     (active),
    .burst_done (burst_done)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wr(input int addr, input int data);
    cfg_we    = 1'b1;
    cfg_addr  = addr[1:0];
    cfg_wdata = data[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Runs one burst and checks all outputs in every cycle against a tick-count model.
  task automatic run_burst(input int z, input int d, input int y, input logic [15:0] pat,
                           input bit stall, input bit midwr, input string tag);
    int  per   = 4 * (z + 1);
    int  total = (y + 1) * per;
    int  tk    = 0;
    int  post  = 0;
    int  cyc   = 0;
    bit  ticked = 0;
    tick_en = 1'b1;
    wr(0, z);
    wr(1, d);
    ser_data = pat[0];
    wr(2, y);                                   // R2: burst starts at this edge
    while (post < 3) begin
      int  ph  = (tk % per) / (z + 1);
      int  j   = tk / per;
      logic act_e  = (tk < total);
      logic done_e = (tk == total) && ticked;
      logic car_e  = act_e && pat[j % 16] && (ph < d);
      chk("R3/R4/R7", {tag, " car_out"}, car_out, car_e);
      chk("R2/R5", {tag, " active"}, active, act_e);
      chk("R6", {tag, " burst_done"}, burst_done, done_e);
      if (tk == total) post++;
      begin
        bit ten = stall ? ((cyc % 3) != 2) : 1'b1;   // R8 stall pattern
        int tk_next = tk + ((ten && tk < total) ? 1 : 0);
        cfg_we = 1'b0;
        if (midwr && cyc == 5) begin             // R9: dropped while active
          cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'((z ^ 5) & 15);
        end
        if (midwr && cyc == 6) begin
          cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 8'((d ^ 1) & 3);
        end
        tick_en  = ten;
        ser_data = pat[(tk_next / per) % 16];
        @(negedge clk);
        ticked = ten && (tk < total);
        tk     = tk_next;
      end
      cyc++;
    end
    cfg_we  = 1'b0;
    tick_en = 1'b1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "car_out in reset", car_out, 1'b0);
    chk("R1", "active in reset", active, 1'b0);
    chk("R1", "burst_done in reset", burst_done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "car_out after reset", car_out, 1'b0);
    chk("R1", "active after reset", active, 1'b0);
    chk("R1", "burst_done after reset", burst_done, 1'b0);
  endtask

  task automatic t_basic();      run_burst(2, 2, 3, 16'hFFFF, 0, 0, "basic R3 R4 R5");  endtask
  task automatic t_minimum();    run_burst(0, 1, 0, 16'hFFFF, 0, 0, "min R5 R6");       endtask
  task automatic t_slow();       run_burst(15, 3, 2, 16'hFFFF, 0, 0, "slow R3");        endtask
  task automatic t_zero_duty();  run_burst(1, 0, 2, 16'hFFFF, 0, 0, "duty0 R4");        endtask
  task automatic t_gate();       run_burst(1, 2, 7, 16'b1011_0010_1101_0110, 0, 0, "gate R7"); endtask
  task automatic t_stall();      run_burst(2, 3, 2, 16'b0110, 1, 0, "stall R8");        endtask
  task automatic t_frozen_cfg(); run_burst(3, 1, 3, 16'hFFFF, 0, 1, "frozen R9");       endtask
  task automatic t_long();       run_burst(0, 2, 255, 16'hF0F5, 0, 0, "long R5");       endtask

  task automatic t_restart();
    wr(0, 3);
    wr(1, 2);
    ser_data = 1'b1;
    wr(2, 9);
    repeat (7) @(negedge clk);
    chk("R10", "active before restart", active, 1'b1);
    run_burst(3, 2, 1, 16'hFFFD, 0, 0, "restart R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_minimum();
    t_slow();
    t_zero_duty();
    t_gate();
    t_stall();
    t_frozen_cfg();
    t_restart();
    t_long();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule